// File: doc/BRIEF.md
# Counter-Mode Seed and Page Counter Manager

This block produces the 128-bit seeds that a counter-mode memory encryption engine turns into pads. Seeds are never derived from a physical or virtual address. Each page tracked by the block owns a logical page identifier and a set of small per-block version counters. Together they form one 64-byte counter record: a 64-bit identifier plus sixty-four 7-bit counters. The identifiers are handed out by a 64-bit global page counter that only ever counts up, so no seed is issued twice.

A requester presents a page index, a 6-bit block offset within the 4 KB page (64-byte blocks) and an operation code over a valid/ready handshake:

- A read miss returns the seed built from the block's present counter and leaves the counter unchanged.
- A write-back first advances the block's counter and then returns the seed built from the new value.
- A page allocation binds the next global identifier to the page and zeroes all of the page's counters.

When a write-back finds its counter already at its maximum, the page is re-keyed. The page takes a fresh identifier and all of its counters are zeroed. No seed is produced for that write-back. A one-cycle re-encryption request carries the page index out of the block, and the block accepts nothing more until the re-encryption is reported complete.

Top module: `seed_ctr_mgr`

## Requirements
- R1: During and after reset, with no request pending, `req_ready` is 1, `seed_valid` is 0 and `reencrypt_req` is 0; the global page counter starts at 1 and every page identifier and block counter is 0.
- R2: An issued seed has bits [127:77] zero, bits [76:13] the page's logical identifier, bits [12:7] the block offset and bits [6:0] the block counter.
- R3: A read miss (`req_op` = 2'b00) returns the seed with the block's current counter and leaves that counter unchanged, so two reads in a row give the same seed.
- R4: A write-back (`req_op` = 2'b01) on a counter below 127 increments the counter by one, and the returned seed carries the incremented value.
- R5: `seed_valid` is high for exactly the one cycle after a read miss or a non-overflowing write-back is accepted; it is low after every other kind of request.
- R6: Page allocation (`req_op` = 2'b10) gives the page the current global counter value as its identifier, zeroes its 64 counters, increments the global counter by one and produces no seed.
- R7: A write-back on a counter equal to 127 produces no seed. It pulses `reencrypt_req` for one cycle with `reencrypt_page` set to the page index. It gives the page the current global counter value as a new identifier, increments the global counter, and zeroes all 64 of the page's counters.
- R8: `req_ready` is 0 from the cycle `reencrypt_req` is high until `reencrypt_done` has been sampled high, and is 1 again in the cycle after that.
- R9: A request on one page leaves the identifier and counters of every other page unchanged.
- R10: `req_op` = 2'b11 is accepted and has no effect on any counter, identifier or output.
- R11: A write-back on one offset leaves the counters of the other offsets of the same page unchanged, including offsets 0 and 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_op | input | 2 | 00 read miss, 01 write-back, 10 allocate page, 11 no operation |
| req_page | input | 4 | Page index into the counter table |
| req_off | input | 6 | Block offset within the page |
| seed_valid | output | 1 | Seed output valid for one cycle |
| seed | output | 128 | Encryption seed |
| reencrypt_req | output | 1 | One-cycle pulse: re-encrypt the named page |
| reencrypt_page | output | 4 | Page to re-encrypt |
| reencrypt_done | input | 1 | Re-encryption finished; releases the stall |

## Verification
A behavioural model of pages, counters and the global counter predicts every response.

Repeated reads of one block separate a read that changes state from one that does not. Write runs on offsets 5, 0 and 63 of one page, each followed by reads of the neighbouring offsets, show whether the counter slice is indexed correctly and written back in place. Allocations on two pages and reads of a third page show that identifiers advance in order and stay with their own page.

A run of 127 write-backs to one block, followed by one more, tells a counter that wraps silently apart from one that re-keys. The stall window is then probed cycle by cycle up to and just past `reencrypt_done`.

// File: rtl/seed_mgr_pkg.sv
package seed_mgr_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_ALLOC = 2'b10,
    OP_NONE  = 2'b11
  } req_op_e;
endpackage

// File: rtl/seed_page_counter.sv
module seed_page_counter #(
  parameter int          LPID_W = 64,
  parameter logic [63:0] START  = 64'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bump,
  output logic [LPID_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) value <= START[LPID_W-1:0];
    else if (bump) value <= value + LPID_W'(1);
  end

  AST_GPC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bump) |-> $stable(value)); // R6
  AST_GPC_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(bump) |-> value == $past(value) + LPID_W'(1)); // R6
endmodule

// File: rtl/seed_ctr_table.sv
module seed_ctr_table #(
  parameter int N_PAGES = 16,
  parameter int BLKS    = 64,
  parameter int CTR_W   = 7,
  parameter int LPID_W  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(N_PAGES)-1:0] rd_page,
  output logic [BLKS*CTR_W-1:0]      rd_row,
  output logic [LPID_W-1:0]          rd_lpid,
  input  logic                       wr_en,
  input  logic [$clog2(N_PAGES)-1:0] wr_page,
  input  logic [BLKS*CTR_W-1:0]      wr_row,
  input  logic                       lpid_we,
  input  logic [LPID_W-1:0]          wr_lpid
);
  localparam int ROW_W = BLKS * CTR_W;

  logic [ROW_W-1:0]  row_mem  [N_PAGES];
  logic [LPID_W-1:0] lpid_mem [N_PAGES];

  assign rd_row  = row_mem[rd_page];
  assign rd_lpid = lpid_mem[rd_page];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_PAGES; i++) begin
        row_mem[i]  <= '0;
        lpid_mem[i] <= '0;
      end
    end else begin
      if (wr_en)   row_mem[wr_page]  <= wr_row;
      if (lpid_we) lpid_mem[wr_page] <= wr_lpid;
    end
  end

  AST_ROW_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> row_mem[$past(wr_page)] == $past(wr_row)); // R4
endmodule

// File: rtl/seed_ctr_mgr.sv
module seed_ctr_mgr #(
  parameter int N_PAGES = 16,
  parameter int BLKS    = 64,
  parameter int CTR_W   = 7,
  parameter int LPID_W  = 64,
  parameter int SEED_W  = 128
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [1:0]                 req_op,
  input  logic [$clog2(N_PAGES)-1:0] req_page,
  input  logic [$clog2(BLKS)-1:0]    req_off,
  output logic                       seed_valid,
  output logic [SEED_W-1:0]          seed,
  output logic                       reencrypt_req,
  output logic [$clog2(N_PAGES)-1:0] reencrypt_page,
  input  logic                       reencrypt_done
);
  import seed_mgr_pkg::*;

  localparam int PG_W  = $clog2(N_PAGES);
  localparam int OFF_W = $clog2(BLKS);
  localparam int ROW_W = BLKS * CTR_W;
  localparam int PAD_W = SEED_W - LPID_W - OFF_W - CTR_W;

  req_op_e           op;
  logic              busy;
  logic              acc, ovf, do_write, do_alloc, emit;
  logic [ROW_W-1:0]  rd_row, new_row, wr_row;
  logic [LPID_W-1:0] rd_lpid, gpc_value;
  logic [CTR_W-1:0]  cur_ctr, next_ctr, out_ctr;
  logic              tbl_wr, lpid_we;

  assign op        = req_op_e'(req_op);
  assign req_ready = !busy;
  assign acc       = req_valid && !busy;
  assign do_write  = acc && (op == OP_WRITE);
  assign do_alloc  = acc && (op == OP_ALLOC);

  assign cur_ctr  = rd_row[req_off*CTR_W +: CTR_W];
  assign next_ctr = cur_ctr + CTR_W'(1);
  assign ovf      = do_write && (&cur_ctr);
  assign out_ctr  = (op == OP_WRITE) ? next_ctr : cur_ctr;
  assign emit     = (acc && op == OP_READ) || (do_write && !ovf);

  always_comb begin
    new_row = rd_row;
    new_row[req_off*CTR_W +: CTR_W] = next_ctr;
  end

  assign tbl_wr  = do_write || do_alloc;
  assign wr_row  = (do_write && !ovf) ? new_row : '0;
  assign lpid_we = ovf || do_alloc;

  seed_ctr_table #(
    .N_PAGES(N_PAGES), .BLKS(BLKS), .CTR_W(CTR_W), .LPID_W(LPID_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .rd_page(req_page), .rd_row(rd_row), .rd_lpid(rd_lpid),
    .wr_en(tbl_wr), .wr_page(req_page), .wr_row(wr_row),
    .lpid_we(lpid_we), .wr_lpid(gpc_value)
  );

  seed_page_counter #(.LPID_W(LPID_W)) u_gpc (
    .clk(clk), .rst(rst), .bump(lpid_we), .value(gpc_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seed_valid     <= 1'b0;
      seed           <= '0;
      reencrypt_req  <= 1'b0;
      reencrypt_page <= '0;
      busy           <= 1'b0;
    end else begin
      seed_valid    <= emit;
      if (emit) seed <= {{PAD_W{1'b0}}, rd_lpid, req_off, out_ctr};
      reencrypt_req <= ovf;
      if (ovf) reencrypt_page <= req_page;
      if (ovf) busy <= 1'b1;
      else if (reencrypt_done) busy <= 1'b0;
    end
  end

  AST_SEED_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    seed_valid |-> $past(req_valid && req_ready)); // R5
  AST_NO_SEED_ON_REKEY: assert property (@(posedge clk) disable iff (rst)
    reencrypt_req |-> !seed_valid); // R7
  AST_REKEY_PULSE: assert property (@(posedge clk) disable iff (rst)
    reencrypt_req |=> !reencrypt_req); // R7
  AST_STALL_AFTER_REKEY: assert property (@(posedge clk) disable iff (rst)
    reencrypt_req |-> !req_ready); // R8
endmodule

// File: tb/seed_ctr_mgr_test.sv
`timescale 1ns/1ps
module seed_ctr_mgr_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic         req_ready;
  logic [1:0]   req_op;
  logic [3:0]   req_page;
  logic [5:0]   req_off;
  logic         seed_valid;
  logic [127:0] seed;
  logic         reencrypt_req;
  logic [3:0]   reencrypt_page;
  logic         reencrypt_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] m_lpid [16];
  int          m_ctr  [16][64];
  logic [63:0] m_gpc;

  always #10 clk = ~clk;

  seed_ctr_mgr uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_page(req_page), .req_off(req_off),
    .seed_valid(seed_valid), .seed(seed),
    .reencrypt_req(reencrypt_req), .reencrypt_page(reencrypt_page),
    .reencrypt_done(reencrypt_done)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [63:0] id, input int off, input int ctr);
    logic [5:0] o;
    logic [6:0] c;
    o = 6'(off);
    c = 7'(ctr);
    return {51'd0, id, o, c};
  endfunction

  // called at a negedge; returns at the negedge after acceptance
  task automatic do_req(input logic [1:0] op, input int p, input int off, input string tag);
    logic         e_sv = 0, e_rr = 0;
    logic [127:0] e_seed = '0;
    chk({tag, " ready before request (R8)"}, 128'(req_ready), 128'(1));
    case (op)
      2'b00: begin e_sv = 1; e_seed = mk(m_lpid[p], off, m_ctr[p][off]); end
      2'b01: begin
        if (m_ctr[p][off] == 127) begin
          m_lpid[p] = m_gpc; m_gpc++;
          for (int k = 0; k < 64; k++) m_ctr[p][k] = 0;
          e_rr = 1;
        end else begin
          m_ctr[p][off]++;
          e_sv = 1; e_seed = mk(m_lpid[p], off, m_ctr[p][off]);
        end
      end
      2'b10: begin
        m_lpid[p] = m_gpc; m_gpc++;
        for (int k = 0; k < 64; k++) m_ctr[p][k] = 0;
      end
      default: ;
    endcase
    req_valid = 1; req_op = op; req_page = 4'(p); req_off = 6'(off);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({tag, " seed_valid (R5)"}, 128'(seed_valid), 128'(e_sv));
    if (e_sv) chk({tag, " seed (R2)"}, seed, e_seed);
    chk({tag, " reencrypt_req (R7)"}, 128'(reencrypt_req), 128'(e_rr));
    if (e_rr) chk({tag, " reencrypt_page (R7)"}, 128'(reencrypt_page), 128'(p));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; req_valid = 0; req_op = 0; req_page = 0; req_off = 0; reencrypt_done = 0;
    m_gpc = 64'd1;
    for (int p = 0; p < 16; p++) begin
      m_lpid[p] = '0;
      for (int k = 0; k < 64; k++) m_ctr[p][k] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 128'(req_ready), 128'(1));
    chk("R1 seed_valid in reset", 128'(seed_valid), 128'(0));
    rst = 0;
    @(negedge clk);
    chk("R1 ready after reset", 128'(req_ready), 128'(1));
    chk("R1 reencrypt_req after reset", 128'(reencrypt_req), 128'(0));
    do_req(2'b00, 2, 4, "R1 unallocated page read");

    do_req(2'b10, 3, 0, "R6 allocate page 3");
    do_req(2'b00, 3, 5, "R3 first read");
    do_req(2'b10, 7, 0, "R6 allocate page 7");
    do_req(2'b00, 7, 5, "R6 page 7 second identifier");
    for (int i = 0; i < 3; i++) do_req(2'b01, 3, 5, "R4 write-back");
    do_req(2'b00, 3, 5, "R3 read after writes");
    do_req(2'b00, 3, 5, "R3 repeated read");
    do_req(2'b01, 3, 63, "R11 write offset 63");
    do_req(2'b01, 3, 0, "R11 write offset 0");
    do_req(2'b00, 3, 5, "R11 offset 5 untouched");
    do_req(2'b00, 3, 62, "R11 offset 62 untouched");
    do_req(2'b00, 7, 5, "R9 other page untouched");
    do_req(2'b11, 3, 5, "R10 no-op");
    do_req(2'b00, 3, 5, "R10 state after no-op");

    do_req(2'b10, 9, 0, "R6 allocate page 9");
    for (int i = 0; i < 127; i++) do_req(2'b01, 9, 10, "R4 count to 127");
    do_req(2'b01, 9, 10, "R7 overflow write");
    chk("R8 ready low at rekey", 128'(req_ready), 128'(0));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 single pulse", 128'(reencrypt_req), 128'(0));
      chk("R8 stalled", 128'(req_ready), 128'(0));
    end
    req_valid = 1; req_op = 2'b01; req_page = 4'd3; req_off = 6'd5;
    @(negedge clk);
    chk("R8 request held off", 128'(seed_valid), 128'(0));
    req_valid = 0;
    reencrypt_done = 1;
    @(negedge clk);
    reencrypt_done = 0;
    chk("R8 ready after done", 128'(req_ready), 128'(1));
    do_req(2'b00, 9, 10, "R7 new id, counter zero");
    do_req(2'b00, 9, 11, "R7 neighbour counter zero");
    do_req(2'b00, 3, 5, "R9 page 3 kept after rekey");
    do_req(2'b10, 4, 0, "R6 allocation after rekey");
    do_req(2'b00, 4, 0, "R6 next identifier");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule